// File: doc/BRIEF.md
# Registered Integer ALU with Branch Compare Flags

This block is the arithmetic and logic engine of the execute stage of a 32-bit integer core. A 4-bit operation code picks one of eleven operations on two operands: bitwise AND, OR and XOR, addition, subtraction, logical and arithmetic shifts, and signed and unsigned set-less-than. The result and three compare flags are captured in registers on the rising clock edge. The flags are less-than, greater-than and zero.

Two operation codes both subtract. They differ only in how the operands are compared when the less-than and greater-than flags are formed. One code compares as signed two's-complement numbers. The other compares as unsigned numbers. From these flags and the zero flag, the surrounding execute stage can resolve every conditional branch. Choosing which flag a given branch tests belongs to that stage, not to this block.

Top module: `int_alu`

## Requirements
- R1: Code 4'b0000 yields opa AND opb, 4'b0001 yields opa OR opb, and 4'b0011 yields opa XOR opb.
- R2: Code 4'b0010 yields opa + opb modulo 2^32; the carry out is discarded.
- R3: Code 4'b0100 shifts opa left, filling with zeros. Code 4'b1000 shifts opa right, filling with zeros. Code 4'b1100 shifts opa right, filling with copies of opa bit 31. The shift distance is opb[4:0] only; opb[31:5] has no effect.
- R4: Code 4'b1010 yields 1 when opa < opb as signed numbers, otherwise 0. Code 4'b0101 yields the same for an unsigned comparison. Bits 31..1 of these results are always 0.
- R5: Code 4'b0110 yields opa - opb modulo 2^32. It sets lt when opa < opb as signed numbers and gt when opa > opb as signed numbers.
- R6: Code 4'b0111 yields opa - opb modulo 2^32. It sets lt and gt from an unsigned comparison of the operands.
- R7: lt and gt are never high together and are both low when the operands are equal. For every code other than 4'b0110 and 4'b0111, both are low whatever the operands.
- R8: For every code, zero is high exactly when the 32-bit result is 0.
- R9: The unused codes 4'b1001, 4'b1011, 4'b1101, 4'b1110 and 4'b1111 yield a result of 0, so zero is high.
- R10: All outputs are registered with one cycle of latency. The outputs change only at a rising clock edge and reflect the inputs sampled at that edge. When rst is high at a rising edge, the result becomes 0, lt and gt become 0, and zero becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand; its low 5 bits give the shift distance |
| res_o | output | 32 | Registered result |
| lt_o | output | 1 | Registered less-than flag (subtract codes only) |
| gt_o | output | 1 | Registered greater-than flag (subtract codes only) |
| zero_o | output | 1 | Registered flag, high when res_o is zero |

## Verification
The properties assume that op_i, opa_i and opb_i hold known values at every rising edge while rst is low. Each property relates those sampled inputs to the registered outputs one edge later. The bench keeps to this assumption in three ways. It drives every input to a defined value before reset is released. It changes inputs only on falling edges. It applies each code, including the unused ones, for exactly one full cycle. Because the block holds no state beyond its output registers, no other input history is needed.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_XOR  = 4'b0011,
    OP_SLL  = 4'b0100,
    OP_SLTU = 4'b0101,
    OP_CMPS = 4'b0110,
    OP_CMPU = 4'b0111,
    OP_SRL  = 4'b1000,
    OP_SLT  = 4'b1010,
    OP_SRA  = 4'b1100
  } alu_op_e;

  function automatic logic is_cmp_op(input logic [3:0] op);
    return (op == OP_CMPS) || (op == OP_CMPU);
  endfunction

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] xor_o
);

  assign and_o = a & b;
  assign or_o  = a | b;
  assign xor_o = a ^ b;

endmodule

// File: rtl/alu_arith_unit.sv
// One adder and one subtractor; both compare results come from the subtractor.
module alu_arith_unit #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] diff_o,
  output logic         lt_s_o,
  output logic         lt_u_o,
  output logic         eq_o
);

  logic         borrow;
  logic [W-1:0] diff;
  logic         ovf;

  assign sum_o = a + b;
  assign {borrow, diff} = {1'b0, a} - {1'b0, b};
  // Signed overflow: operand signs differ and the difference takes b's sign.
  assign ovf    = (a[W-1] ^ b[W-1]) & (diff[W-1] ^ a[W-1]);
  assign diff_o = diff;
  assign lt_u_o = borrow;
  assign lt_s_o = diff[W-1] ^ ovf;
  assign eq_o   = (diff == '0);

endmodule

// File: rtl/alu_shift_unit.sv
// Log-depth right shifter; left shifts reverse the bits before and after.
module alu_shift_unit #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   val,
  input  logic [SHW-1:0] amt,
  input  logic           to_left,
  input  logic           arith,
  output logic [W-1:0]   res
);

  function automatic logic [W-1:0] bit_rev(input logic [W-1:0] x);
    logic [W-1:0] y;
    for (int i = 0; i < W; i++) y[i] = x[W-1-i];
    return y;
  endfunction

  logic [SHW:0][W-1:0] stage;
  logic                fill;

  assign fill     = arith & ~to_left & val[W-1];
  assign stage[0] = to_left ? bit_rev(val) : val;

  for (genvar g = 0; g < SHW; g++) begin : g_stage
    localparam int S = 1 << g;
    assign stage[g+1] = amt[g] ? {{S{fill}}, stage[g][W-1:S]} : stage[g];
  end

  assign res = to_left ? bit_rev(stage[SHW]) : stage[SHW];

endmodule

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic [W-1:0] res_o,
  output logic         lt_o,
  output logic         gt_o,
  output logic         zero_o
);
  import alu_pkg::*;

  localparam int SHW = $clog2(W);

  logic [W-1:0] and_v, or_v, xor_v, sum_v, diff_v, shift_v;
  logic         lt_s, lt_u, eq;
  logic         sh_left, sh_arith;
  logic [W-1:0] nxt_res;
  logic         nxt_lt, nxt_gt;

  alu_logic_unit #(.W(W)) u_logic (
    .a(opa_i), .b(opb_i), .and_o(and_v), .or_o(or_v), .xor_o(xor_v)
  );

  alu_arith_unit #(.W(W)) u_arith (
    .a(opa_i), .b(opb_i), .sum_o(sum_v), .diff_o(diff_v),
    .lt_s_o(lt_s), .lt_u_o(lt_u), .eq_o(eq)
  );

  assign sh_left  = (op_i == OP_SLL);
  assign sh_arith = (op_i == OP_SRA);

  alu_shift_unit #(.W(W), .SHW(SHW)) u_shift (
    .val(opa_i), .amt(opb_i[SHW-1:0]), .to_left(sh_left),
    .arith(sh_arith), .res(shift_v)
  );

  always_comb begin
    nxt_res = '0;
    nxt_lt  = 1'b0;
    nxt_gt  = 1'b0;
    case (op_i)
      OP_AND:  nxt_res = and_v;
      OP_OR:   nxt_res = or_v;
      OP_XOR:  nxt_res = xor_v;
      OP_ADD:  nxt_res = sum_v;
      OP_SLL,
      OP_SRL,
      OP_SRA:  nxt_res = shift_v;
      OP_SLT:  nxt_res = {{(W-1){1'b0}}, lt_s};
      OP_SLTU: nxt_res = {{(W-1){1'b0}}, lt_u};
      OP_CMPS: begin
        nxt_res = diff_v;
        nxt_lt  = lt_s;
        nxt_gt  = ~lt_s & ~eq;
      end
      OP_CMPU: begin
        nxt_res = diff_v;
        nxt_lt  = lt_u;
        nxt_gt  = ~lt_u & ~eq;
      end
      default: nxt_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= '0;
      lt_o   <= 1'b0;
      gt_o   <= 1'b0;
      zero_o <= 1'b1;
    end else begin
      res_o  <= nxt_res;
      lt_o   <= nxt_lt;
      gt_o   <= nxt_gt;
      zero_o <= (nxt_res == '0);
    end
  end

endmodule

// File: rtl/int_alu_checks.sv
module int_alu_checks #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op_i,
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic [W-1:0] res_o,
  input logic         lt_o,
  input logic         gt_o,
  input logic         zero_o
);
  import alu_pkg::*;

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(lt_o && gt_o));

  a_r8_zero_tracks_result: assert property (@(posedge clk) disable iff (rst)
    zero_o == (res_o == '0));

  a_r7_flags_low_off_cmp: assert property (@(posedge clk) disable iff (rst)
    (!is_cmp_op(op_i)) |=> (!lt_o && !gt_o));

  a_r7_equal_no_order: assert property (@(posedge clk) disable iff (rst)
    (is_cmp_op(op_i) && opa_i == opb_i) |=> (zero_o && !lt_o && !gt_o));

  a_r4_slt_single_bit: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SLT || op_i == OP_SLTU) |=> (res_o[W-1:1] == '0));

  a_r9_unused_is_zero: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'b1001 || op_i == 4'b1011 || op_i == 4'b1101 ||
     op_i == 4'b1110 || op_i == 4'b1111) |=> (res_o == '0));

  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (res_o == '0 && !lt_o && !gt_o && zero_o));

endmodule

bind int_alu int_alu_checks #(.W(W)) u_checks (
  .clk(clk), .rst(rst), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
  .res_o(res_o), .lt_o(lt_o), .gt_o(gt_o), .zero_o(zero_o)
);

// File: tb/int_alu_test.sv
module int_alu_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        lt;
    logic        gt;
    logic        z;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'b0000, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200, 1'b0, 1'b0, 1'b0},
    '{4'b0001, 32'hF000_0000, 32'h0000_000F, 32'hF000_000F, 1'b0, 1'b0, 1'b0},
    '{4'b0011, 32'hFFFF_0000, 32'hFFFF_0000, 32'h0000_0000, 1'b0, 1'b0, 1'b1},
    '{4'b0010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b0, 1'b1},
    '{4'b0010, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b0, 1'b0},
    '{4'b0100, 32'h0000_0001, 32'h0000_0024, 32'h0000_0010, 1'b0, 1'b0, 1'b0},
    '{4'b1000, 32'h8000_0000, 32'h0000_001F, 32'h0000_0001, 1'b0, 1'b0, 1'b0},
    '{4'b1100, 32'h8000_0000, 32'h0000_001F, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0},
    '{4'b1100, 32'h4000_0000, 32'h0000_003E, 32'h0000_0001, 1'b0, 1'b0, 1'b0},
    '{4'b0100, 32'hDEAD_BEEF, 32'h0000_0020, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0},
    '{4'b1010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, 1'b0},
    '{4'b0101, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b0, 1'b1},
    '{4'b0101, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 1'b0},
    '{4'b0110, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b0, 1'b0, 1'b1},
    '{4'b0110, 32'hFFFF_FFFE, 32'h0000_0003, 32'hFFFF_FFFB, 1'b1, 1'b0, 1'b0},
    '{4'b0110, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 1'b1, 1'b0, 1'b0},
    '{4'b0110, 32'h0000_0007, 32'h0000_0003, 32'h0000_0004, 1'b0, 1'b1, 1'b0},
    '{4'b0111, 32'hFFFF_FFFE, 32'h0000_0003, 32'hFFFF_FFFB, 1'b0, 1'b1, 1'b0},
    '{4'b0111, 32'h0000_0001, 32'h0000_0002, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0},
    '{4'b0010, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 1'b0, 1'b0, 1'b0},
    '{4'b1001, 32'h0000_0001, 32'h0000_0002, 32'h0000_0000, 1'b0, 1'b0, 1'b1},
    '{4'b1111, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_0000, 1'b0, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op  = 4'b0000;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [31:0] res;
  logic        lt, gt, zero;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu uut (
    .clk(clk), .rst(rst), .op_i(op), .opa_i(opa), .opb_i(opb),
    .res_o(res), .lt_o(lt), .gt_o(gt), .zero_o(zero)
  );

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'b0000, 4'b0001, 4'b0011: return "R1";
      4'b0010:                   return "R2";
      4'b0100, 4'b1000, 4'b1100: return "R3";
      4'b1010, 4'b0101:          return "R4";
      4'b0110:                   return "R5";
      4'b0111:                   return "R6";
      default:                   return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] er,
                       input logic el, input logic eg, input logic ez);
    total++;
    if (res !== er || lt !== el || gt !== eg || zero !== ez) begin
      bad++;
      $display("FAIL %s: got res=%h lt=%b gt=%b z=%b, want res=%h lt=%b gt=%b z=%b",
               req, res, lt, gt, zero, er, el, eg, ez);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op = o; opa = a; opb = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R10: reset state
    check("R10", 32'h0, 1'b0, 1'b0, 1'b1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].b);
      check(tag_of(VECS[i].op), VECS[i].res, VECS[i].lt, VECS[i].gt, VECS[i].z);
      // R8: zero flag must agree with the result for every vector
      total++;
      if (zero !== (res == 32'h0)) begin
        bad++;
        $display("FAIL R8: zero=%b res=%h, want zero=%b", zero, res, (res == 32'h0));
      end
    end

    // R7: different operands under a non-compare code keep both flags low
    apply(4'b0011, 32'h0000_0001, 32'hFFFF_FFFF);
    check("R7", 32'hFFFF_FFFE, 1'b0, 1'b0, 1'b0);

    // R10: outputs hold until the edge after the inputs change
    apply(4'b0110, 32'h0000_0002, 32'h0000_0009);
    @(negedge clk);
    op = 4'b0010; opa = 32'h0000_0010; opb = 32'h0000_0020;
    #1;
    check("R10", 32'hFFFF_FFF9, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check("R10", 32'h0000_0030, 1'b0, 1'b0, 1'b0);

    // R10: reset in mid-run clears flags and result
    apply(4'b0111, 32'h0000_0001, 32'h0000_0002);
    rst = 1'b1;
    @(negedge clk);
    check("R10", 32'h0, 1'b0, 1'b0, 1'b1);
    rst = 1'b0;

    // R3: high bits of the shift operand ignored for arithmetic shift of a positive value
    apply(4'b1100, 32'h7000_0000, 32'hFFFF_FFE4);
    check("R3", 32'h0700_0000, 1'b0, 1'b0, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule